// File: doc/BRIEF.md
# Asynchronous Write Packet Assembler

This block builds outgoing asynchronous write request packets for a serial-bus link layer. It takes payload quadlets from one of two feeders: a streaming data port, or a host register port. It then passes a quadlet stream to the transmitter, with a first marker and a last marker on each packet. A configuration setting picks the mode. In register-header mode the block takes four header quadlets from configuration inputs and puts them ahead of the payload. In inline mode the incoming stream already carries its own header.

The block decides where each packet ends. An end can come from an explicit end flag sent by the feeder. It can also come from a byte count: the block counts payload bytes and compares the total with the length field of the header. When the last quadlet is only partly filled, the unused bytes are zero-filled. The output is a valid/ready stream and handles back-pressure. If a register header carries a transaction code that automatic insertion does not support, the block reports it and discards that packet.

Top module: `awp_top`

## Requirements
- R1: While `cfg_enable` is low and no packet is in progress, no packet starts: `st_ready`, `hp_ready` and `tx_valid` stay low.
- R2: With `cfg_hdr_reg`=1 the four quadlets of `cfg_hdr` are sent first, in the order bits [31:0], [63:32], [95:64], [127:96], followed by the payload. `tx_first` is set only on the first header quadlet.
- R3: With `cfg_hdr_reg`=0 the input quadlets are forwarded unchanged and in order, apart from end padding. The first input quadlet carries `tx_first`.
- R4: `cfg_src_stream`=1 selects the streaming port and `cfg_src_stream`=0 selects the host port. The port that is not selected never sees its ready signal raised.
- R5: An explicit end ends the packet on that quadlet and raises `tx_last` there. The streaming port signals it with `st_fmt[2]`=1; the host port signals it with `hp_send`=1. The 2-bit byte code (`st_fmt[1:0]` or `hp_nb`) plus one gives the number of valid bytes, counted from bits [31:24] downwards. The remaining bytes are sent as zero.
- R6: The transaction code sits in header quadlet 0 bits [7:4], and the data length sits in quadlet 3 bits [31:16]. For code 1 with a non-zero length, the packet ends without any flag on the payload quadlet that brings the byte count to the length. For code 0 it ends after one payload quadlet.
- R7: When an end found by byte count falls inside a quadlet, only the (length mod 4) leading bytes are kept and the rest are zero. The header length field is sent unchanged.
- R8: In register-header mode, a code other than 0 or 1 raises `err_tcode` for exactly one cycle. Nothing of that packet reaches `tx_*`, and its input quadlets are consumed up to its end.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_first` and `tx_last` hold. Every quadlet appears exactly once.
- R10: The source select, the header mode and the header contents are sampled when a packet starts. Changes made during the packet do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Master enable for starting packets |
| cfg_src_stream | input | 1 | 1 selects streaming port, 0 host port |
| cfg_hdr_reg | input | 1 | 1 inserts header from `cfg_hdr`, 0 header inline |
| cfg_hdr | input | 128 | Four header quadlets, quadlet 0 in the low bits |
| st_valid | input | 1 | Streaming quadlet valid |
| st_ready | output | 1 | Streaming quadlet accepted |
| st_data | input | 32 | Streaming quadlet |
| st_fmt | input | 3 | Bit 2 end flag, bits 1:0 valid bytes minus one |
| hp_valid | input | 1 | Host quadlet valid |
| hp_ready | output | 1 | Host quadlet accepted |
| hp_data | input | 32 | Host quadlet |
| hp_send | input | 1 | Host end-and-send flag |
| hp_nb | input | 2 | Host valid bytes minus one on end |
| tx_valid | output | 1 | Output quadlet valid |
| tx_ready | input | 1 | Transmitter accepts quadlet |
| tx_data | output | 32 | Output quadlet |
| tx_first | output | 1 | First quadlet of packet |
| tx_last | output | 1 | Last quadlet of packet |
| err_tcode | output | 1 | One-cycle pulse on rejected register header |

## Verification
The hardest case to reach is an end found by byte count while the output is stalled. The length must stop part-way through a quadlet, and the stall must hold the padded final quadlet at the output, so several independent conditions have to line up in one cycle. The stimulus table combines lengths that are not multiples of four with a repeating `tx_ready` stall pattern on both ports and in both header modes. A directed test changes the mode and header inputs in the middle of a packet to show that the values sampled at packet start are the ones used.

// File: rtl/awp_pkg.sv
`timescale 1ns/1ps
package awp_pkg;
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY, S_DROP} awp_state_e;

  // transaction code of header quadlet 0
  function automatic logic [3:0] hdr_tcode(input logic [31:0] q0);
    return q0[7:4];
  endfunction

  // data-length field of the last header quadlet
  function automatic logic [15:0] hdr_len(input logic [31:0] q3);
    return q3[31:16];
  endfunction

  function automatic logic tcode_ok(input logic [3:0] tc);
    return (tc == 4'd0) || (tc == 4'd1);
  endfunction

  // keep the leading bytes (bits 31:24 first), zero the rest
  function automatic logic [31:0] pad_q(input logic [31:0] d, input logic [2:0] keep);
    logic [31:0] m;
    case (keep)
      3'd1:    m = 32'hFF00_0000;
      3'd2:    m = 32'hFFFF_0000;
      3'd3:    m = 32'hFFFF_FF00;
      default: m = 32'hFFFF_FFFF;
    endcase
    return d & m;
  endfunction
endpackage

// File: rtl/awp_mode_dec.sv
`timescale 1ns/1ps
module awp_mode_dec (
  input  logic en,
  input  logic src_stream,
  input  logic hdr_reg,
  output logic active,
  output logic use_stream,
  output logic ins_hdr
);
  assign active     = en;
  assign use_stream = src_stream;
  assign ins_hdr    = en & hdr_reg;
endmodule

// File: rtl/awp_src_mux.sv
`timescale 1ns/1ps
module awp_src_mux #(
  parameter int QW = 32
) (
  input  logic          sel_st,
  input  logic          take,
  input  logic          st_valid,
  input  logic [QW-1:0] st_data,
  input  logic [2:0]    st_fmt,
  input  logic          hp_valid,
  input  logic [QW-1:0] hp_data,
  input  logic          hp_send,
  input  logic [1:0]    hp_nb,
  output logic          in_valid,
  output logic [QW-1:0] in_data,
  output logic          in_last,
  output logic [1:0]    in_nb,
  output logic          st_ready,
  output logic          hp_ready
);
  assign st_ready = take & sel_st;
  assign hp_ready = take & ~sel_st;
  assign in_valid = sel_st ? st_valid   : hp_valid;
  assign in_data  = sel_st ? st_data    : hp_data;
  assign in_last  = sel_st ? st_fmt[2]  : hp_send;
  assign in_nb    = sel_st ? st_fmt[1:0] : hp_nb;
endmodule

// File: rtl/awp_end_calc.sv
`timescale 1ns/1ps
module awp_end_calc #(
  parameter int LW = 16
) (
  input  logic          in_last,
  input  logic [1:0]    in_nb,
  input  logic          payload,
  input  logic          auto_en,
  input  logic [LW-1:0] len,
  input  logic [LW:0]   bcnt,
  output logic          is_end,
  output logic [2:0]    keep
);
  localparam int CW = LW + 1;
  logic [CW-1:0] rem_w;
  logic          cnt_end_w;

  always_comb begin
    rem_w     = {1'b0, len} - bcnt;
    cnt_end_w = payload && auto_en && ({1'b0, len} <= bcnt + CW'(4));
    keep      = in_last ? ({1'b0, in_nb} + 3'd1) : 3'd4;
    if (cnt_end_w && (rem_w < CW'(keep))) keep = rem_w[2:0];
    is_end    = in_last || cnt_end_w;
  end
endmodule

// File: rtl/awp_top.sv
`timescale 1ns/1ps
module awp_top
  import awp_pkg::*;
#(
  parameter int QW   = 32,
  parameter int LW   = 16,
  parameter int NHDR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_src_stream,
  input  logic               cfg_hdr_reg,
  input  logic [NHDR*QW-1:0] cfg_hdr,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic [QW-1:0]      st_data,
  input  logic [2:0]         st_fmt,
  input  logic               hp_valid,
  output logic               hp_ready,
  input  logic [QW-1:0]      hp_data,
  input  logic               hp_send,
  input  logic [1:0]         hp_nb,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [QW-1:0]      tx_data,
  output logic               tx_first,
  output logic               tx_last,
  output logic               err_tcode
);
  localparam int HIW = $clog2(NHDR + 1);
  localparam int HSW = (NHDR > 1) ? $clog2(NHDR) : 1;
  localparam int CW  = LW + 1;
  localparam logic [HIW-1:0] IDX_PAY = HIW'(NHDR);
  localparam logic [HIW-1:0] IDX_LEN = HIW'(NHDR - 1);

  awp_state_e              state_q;
  logic [HIW-1:0]          hidx_q;
  logic [CW-1:0]           bcnt_q;
  logic [NHDR-1:0][QW-1:0] hdr_q;
  logic [3:0]              tc_q;
  logic [LW-1:0]           len_q;
  logic                    src_q, first_q, err_q;

  logic          active_w, use_st_w, ins_w;
  logic          sel_st_w, take_w, fire_w;
  logic          in_valid_w, in_last_w;
  logic [QW-1:0] in_data_w;
  logic [1:0]    in_nb_w;
  logic          out_free_w, in_pay_w, auto_en_w;
  logic [LW-1:0] len_eff_w;
  logic          is_end_w;
  logic [2:0]    keep_w;
  // named events, also observed by the checker
  logic          start_w, bad_w, hdr_load_w, pay_load_w, load_w;
  logic          pkt_idle_w, in_drop_w;

  awp_mode_dec u_mode (
    .en(cfg_enable), .src_stream(cfg_src_stream), .hdr_reg(cfg_hdr_reg),
    .active(active_w), .use_stream(use_st_w), .ins_hdr(ins_w)
  );

  awp_src_mux #(.QW(QW)) u_mux (
    .sel_st(sel_st_w), .take(take_w),
    .st_valid(st_valid), .st_data(st_data), .st_fmt(st_fmt),
    .hp_valid(hp_valid), .hp_data(hp_data), .hp_send(hp_send), .hp_nb(hp_nb),
    .in_valid(in_valid_w), .in_data(in_data_w), .in_last(in_last_w), .in_nb(in_nb_w),
    .st_ready(st_ready), .hp_ready(hp_ready)
  );

  awp_end_calc #(.LW(LW)) u_end (
    .in_last(in_last_w), .in_nb(in_nb_w), .payload(in_pay_w), .auto_en(auto_en_w),
    .len(len_eff_w), .bcnt(bcnt_q), .is_end(is_end_w), .keep(keep_w)
  );

  always_comb begin
    out_free_w = !tx_valid || tx_ready;
    in_pay_w   = (hidx_q == IDX_PAY);
    pkt_idle_w = (state_q == S_IDLE);
    in_drop_w  = (state_q == S_DROP);
    sel_st_w   = pkt_idle_w ? use_st_w : src_q;
    take_w     = ((state_q == S_PAY) && out_free_w) || in_drop_w;
    fire_w     = take_w && in_valid_w;
    auto_en_w  = (tc_q == 4'd0) || ((tc_q == 4'd1) && (len_q != '0));
    len_eff_w  = (tc_q == 4'd0) ? LW'(4) : len_q;
    start_w    = pkt_idle_w && active_w && in_valid_w;
    bad_w      = start_w && ins_w && !tcode_ok(hdr_tcode(cfg_hdr[31:0]));
    hdr_load_w = (state_q == S_HDR) && out_free_w;
    pay_load_w = (state_q == S_PAY) && fire_w;
    load_w     = hdr_load_w || pay_load_w;
  end

  assign err_tcode = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      hidx_q   <= '0;
      bcnt_q   <= '0;
      hdr_q    <= '0;
      tc_q     <= '0;
      len_q    <= '0;
      src_q    <= 1'b0;
      first_q  <= 1'b0;
      err_q    <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      err_q <= bad_w;
      if (out_free_w) begin
        tx_valid <= load_w;
        if (load_w) begin
          tx_data  <= hdr_load_w ? hdr_q[hidx_q[HSW-1:0]] : pad_q(in_data_w, keep_w);
          tx_first <= first_q;
          tx_last  <= pay_load_w && is_end_w;
        end
      end
      if (load_w) first_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_w) begin
            src_q   <= use_st_w;
            first_q <= 1'b1;
            bcnt_q  <= '0;
            if (ins_w) begin
              hdr_q <= cfg_hdr;
              tc_q  <= hdr_tcode(cfg_hdr[31:0]);
              len_q <= LW'(hdr_len(cfg_hdr[NHDR*QW-1 -: QW]));
              if (bad_w) begin
                state_q <= S_DROP;
                hidx_q  <= IDX_PAY;
              end else begin
                state_q <= S_HDR;
                hidx_q  <= '0;
              end
            end else begin
              state_q <= S_PAY;
              hidx_q  <= '0;
            end
          end
        end
        S_HDR: begin
          if (hdr_load_w) begin
            if (hidx_q == IDX_LEN) begin
              hidx_q  <= IDX_PAY;
              state_q <= S_PAY;
            end else begin
              hidx_q <= hidx_q + 1'b1;
            end
          end
        end
        S_PAY: begin
          if (fire_w) begin
            if (in_pay_w) begin
              bcnt_q <= bcnt_q + CW'(4);
            end else begin
              if (hidx_q == '0)     tc_q  <= hdr_tcode(in_data_w[31:0]);
              if (hidx_q == IDX_LEN) len_q <= LW'(hdr_len(in_data_w[31:0]));
              hidx_q <= hidx_q + 1'b1;
            end
            if (is_end_w) state_q <= S_IDLE;
          end
        end
        S_DROP: begin
          if (fire_w) begin
            bcnt_q <= bcnt_q + CW'(4);
            if (is_end_w) state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/awp_chk.sv
`timescale 1ns/1ps
module awp_chk #(
  parameter int QW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_enable,
  input logic          st_ready,
  input logic          hp_ready,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [QW-1:0] tx_data,
  input logic          tx_first,
  input logic          tx_last,
  input logic          err_tcode,
  input logic          pkt_idle,
  input logic          in_drop,
  input logic          out_load
);
  // R1: disabled and idle stays idle
  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && pkt_idle) |=> pkt_idle);

  // R2: after a last quadlet is taken, the next valid quadlet opens a packet
  p_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> (!tx_valid || tx_first));

  // R4: never both feeders ready
  p_one_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_ready && hp_ready));

  // R8: error is a single-cycle pulse
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_tcode |=> !err_tcode);

  // R8: a rejected packet loads nothing into the output
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_drop |-> !out_load);

  // R9: stalled output holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)));
endmodule

bind awp_top awp_chk #(.QW(QW)) u_awp_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .st_ready(st_ready), .hp_ready(hp_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_first(tx_first), .tx_last(tx_last), .err_tcode(err_tcode),
  .pkt_idle(pkt_idle_w), .in_drop(in_drop_w), .out_load(load_w)
);

// File: tb/test_awp_top.sv
`timescale 1ns/1ps
module test_awp_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_enable = 1'b0, cfg_src_stream = 1'b1, cfg_hdr_reg = 1'b1;
  logic [127:0] cfg_hdr = '0;
  logic         st_valid = 1'b0;
  logic         st_ready;
  logic [31:0]  st_data = '0;
  logic [2:0]   st_fmt = '0;
  logic         hp_valid = 1'b0;
  logic         hp_ready;
  logic [31:0]  hp_data = '0;
  logic         hp_send = 1'b0;
  logic [1:0]   hp_nb = '0;
  logic         tx_valid;
  logic         tx_ready = 1'b1;
  logic [31:0]  tx_data;
  logic         tx_first, tx_last, err_tcode;

  always #2.5 clk = ~clk;

  awp_top i_awp_top (.*);

  typedef struct packed {
    logic        stall;
    logic        src_st;
    logic        hreg;
    logic        lastf;
    logic [1:0]  nb;
    logic [3:0]  tc;
    logic [15:0] len;
    logic [7:0]  nq;
    logic [7:0]  exp_n;
    logic [2:0]  exp_keep;
    logic        exp_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,1'b0,2'd0,4'd1,16'd12, 8'd3,8'd7,3'd4,1'b0},
    '{1'b0,1'b0,1'b1,1'b0,2'd0,4'd1,16'd10, 8'd3,8'd7,3'd2,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,2'd2,4'd1,16'd100,8'd2,8'd6,3'd3,1'b0},
    '{1'b0,1'b0,1'b0,1'b0,2'd0,4'd1,16'd8,  8'd6,8'd6,3'd4,1'b0},
    '{1'b1,1'b1,1'b0,1'b0,2'd0,4'd1,16'd6,  8'd6,8'd6,3'd2,1'b0},
    '{1'b0,1'b1,1'b1,1'b0,2'd0,4'd0,16'd0,  8'd1,8'd5,3'd4,1'b0},
    '{1'b1,1'b0,1'b1,1'b0,2'd0,4'd1,16'd7,  8'd2,8'd6,3'd3,1'b0},
    '{1'b0,1'b0,1'b1,1'b1,2'd0,4'd1,16'd200,8'd1,8'd5,3'd1,1'b0},
    '{1'b0,1'b1,1'b1,1'b1,2'd3,4'd4,16'd8,  8'd2,8'd0,3'd4,1'b1}
  };
  string TAGS [NV] = '{"R2 R6", "R4 R7", "R5", "R3 R6", "R9 R7", "R6", "R9 R7", "R5 R4", "R8"};

  int checks = 0, fails = 0;
  int out_n = 0, err_cnt = 0, wrong_rdy = 0, cyc = 0;
  bit stall_en = 1'b0, mon_src = 1'b0;
  logic [31:0] ob [64];
  logic        of [64];
  logic        ol [64];
  logic [31:0] in_w [16];
  logic [31:0] exp_w [16];
  int          n_exp;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // stall pattern and observation, both away from the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    tx_ready = !stall_en || ((cyc % 3) != 1);
  end

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (out_n < 64) begin
        ob[out_n] = tx_data;
        of[out_n] = tx_first;
        ol[out_n] = tx_last;
      end
      out_n++;
    end
    if (rst_n && err_tcode) err_cnt++;
    if (mon_src && ((!cfg_src_stream && st_ready) || (cfg_src_stream && hp_ready))) wrong_rdy++;
  end

  function automatic logic [31:0] hword(int k, logic [3:0] tc, logic [15:0] len, int v);
    case (k)
      0:       return {16'hFFC0, 6'(v), 2'b01, tc, 4'h0};
      1:       return 32'hFFFF_0000 | 32'(v);
      2:       return 32'hF000_0400;
      default: return {len, 16'h0000};
    endcase
  endfunction

  function automatic logic [31:0] pword(int i, int v);
    return 32'(32'h1122_3344 + i * 32'h0101_0101 + (v << 28));
  endfunction

  function automatic logic [31:0] trim(logic [31:0] d, int keep);
    logic [31:0] r;
    r = d;
    for (int b = 0; b < 4; b++) if (b >= keep) r[31-8*b -: 8] = 8'h00;
    return r;
  endfunction

  task automatic build(vec_t t, int v);
    cfg_hdr = {hword(3, t.tc, t.len, v), hword(2, t.tc, t.len, v),
               hword(1, t.tc, t.len, v), hword(0, t.tc, t.len, v)};
    for (int i = 0; i < int'(t.nq); i++)
      in_w[i] = (!t.hreg && i < 4) ? hword(i, t.tc, t.len, v) : pword(i, v);
    n_exp = int'(t.exp_n);
    for (int i = 0; i < n_exp; i++)
      exp_w[i] = t.hreg ? ((i < 4) ? hword(i, t.tc, t.len, v) : in_w[i-4]) : in_w[i];
    if (n_exp > 0) exp_w[n_exp-1] = trim(exp_w[n_exp-1], int'(t.exp_keep));
  endtask

  task automatic send(vec_t t);
    for (int i = 0; i < int'(t.nq); i++) begin
      logic lst;
      lst = t.lastf && (i == int'(t.nq) - 1);
      if (t.src_st) begin
        st_valid = 1'b1; st_data = in_w[i]; st_fmt = lst ? {1'b1, t.nb} : 3'b000;
      end else begin
        hp_valid = 1'b1; hp_data = in_w[i]; hp_send = lst; hp_nb = t.nb;
      end
      @(negedge clk);
      while (!(t.src_st ? st_ready : hp_ready)) @(negedge clk);
      @(posedge clk); #1;
      st_valid = 1'b0; hp_valid = 1'b0; hp_send = 1'b0; st_fmt = 3'b000;
    end
  endtask

  task automatic compare(string tg, int exp_err);
    int bad;
    bit mk;
    chk(out_n == n_exp, tg, "quadlet count", out_n, n_exp);
    bad = -1;
    for (int j = 0; j < n_exp && j < out_n; j++)
      if (bad < 0 && ob[j] !== exp_w[j]) bad = j;
    if (bad >= 0) chk(1'b0, tg, "quadlet data", ob[bad], exp_w[bad]);
    else          chk(1'b1, tg, "quadlet data", 0, 0);
    mk = 1'b1;
    for (int j = 0; j < n_exp && j < out_n; j++)
      if (of[j] !== (j == 0) || ol[j] !== (j == n_exp - 1)) mk = 1'b0;
    chk(mk, tg, "first/last markers", mk, 1);
    chk(err_cnt == exp_err, tg, "error pulses", err_cnt, exp_err);
  endtask

  task automatic run_vec(int v);
    vec_t t;
    t = VEC[v];
    build(t, v);
    cfg_src_stream = t.src_st;
    cfg_hdr_reg    = t.hreg;
    stall_en       = t.stall;
    out_n = 0; err_cnt = 0;
    @(posedge clk); #1;
    send(t);
    repeat (30) @(negedge clk);
    compare(TAGS[v], int'(t.exp_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] keep_hdr;
    int seen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !st_ready && !hp_ready && !err_tcode, "R1", "reset outputs",
        {tx_valid, st_ready, hp_ready, err_tcode}, 0);
    // R1 disabled: offered data is not taken
    @(posedge clk); #1;
    st_valid = 1'b1; st_data = 32'hDEAD_BEEF; hp_valid = 1'b1;
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (st_ready || hp_ready || tx_valid) seen++;
    end
    chk(seen == 0, "R1", "activity while disabled", seen, 0);
    @(posedge clk); #1;
    st_valid = 1'b0; hp_valid = 1'b0;
    cfg_enable = 1'b1;
    mon_src = 1'b1;

    for (int v = 0; v < NV; v++) run_vec(v);

    // R4: unselected feeder never readied
    chk(wrong_rdy == 0, "R4", "unselected port ready", wrong_rdy, 0);
    mon_src = 1'b0;

    // R10: inputs changed mid-packet are ignored
    build(VEC[0], 3);
    keep_hdr = cfg_hdr;
    cfg_src_stream = 1'b1; cfg_hdr_reg = 1'b1; stall_en = 1'b1;
    out_n = 0; err_cnt = 0;
    @(posedge clk); #1;
    fork
      send(VEC[0]);
      begin
        wait (out_n >= 1);
        @(posedge clk); #1;
        cfg_hdr = ~keep_hdr;
        cfg_src_stream = 1'b0;
        cfg_hdr_reg = 1'b0;
      end
    join
    repeat (30) @(negedge clk);
    compare("R10", 0);
    cfg_hdr = keep_hdr;

    summary();
    $finish;
  end
endmodule